// File: doc/BRIEF.md
# Multi-Socket Link Mode Switching Agent

This block is the per-socket controller that moves a whole multi-socket system between two pin configurations. In single-link mode the socket uses all its memory channels and one inter-socket link. In multi-link mode a pair of memory controllers is switched off and their pins are rerouted as extra inter-socket link lanes. Every socket holds one agent. Exactly one agent, chosen by a strap input derived from the processor number, acts as launcher. All the others act as assistants. All sockets always change together.

The change is a two-phase agreement. When a decision interval ends, the launcher checks whether the local traffic hint prefers the other mode. If it does, the launcher polls every peer with an inquiry. A single deny aborts the change, and so does silence for a parameterised number of cycles. Once every peer has approved, the launcher sends a commit request to all peers, and each agent then runs its local sequence through pulse-acknowledged enable outputs. The order of the extra-lane receiver and sender enables is reversed between the two directions, so that no sender ever drives a lane whose far receiver is off. Neighbours exchange done messages to pace that ordering.

Messages to and from each peer travel on abstract ports: one valid bit and a 3-bit type per peer. The physical pin switches, the memory controllers and the link layer sit outside this block.

Top module: `xlink_mode_agent`

## Requirements
- R1: After reset, mode_multi, busy, mc_off and pin_sel are 0, rx_en and tx_en are all 0, and no message is sent.
- R2: An idle launcher that sees eval_tick while want_multi differs from mode_multi sends an inquiry (type 1) to every peer in the next cycle and becomes busy. If want_multi equals mode_multi, eval_tick has no effect. Message types are 0 none, 1 inquiry, 2 approve, 3 deny, 4 request, 5 done. The type for peer p sits in msg_*_typ bits [3p+2:3p].
- R3: An idle assistant that receives an inquiry replies in the next cycle to that peer only, taking the lowest index if several peers inquire at once. It replies approve (2) if want_multi differs from mode_multi and deny (3) otherwise. Only an approve makes it busy.
- R4: A deny from any peer during polling aborts the change at once, even if the last approval arrives in the same cycle. No request is sent and no local output changes.
- R5: A launcher that lacks some approval for TIMEOUT cycles after its inquiry, or an assistant that gets no request for TIMEOUT cycles after approving, returns to idle with its mode unchanged.
- R6: Once approvals from all peers are in, whether they arrive together or over several cycles, the launcher sends a request (4) to every peer in the next cycle. An assistant starts its local sequence when it receives a request.
- R7: Going to multi-link mode, an agent asserts mc_off, then sets pin_sel after mc_ack, then enables every receiver after pin_ack. Done (5) goes out to every peer in the cycle in which the receivers come on.
- R8: Going to multi-link mode, tx_en[p] is set only after a done from peer p. A done that arrives while the local sequence is still running is remembered.
- R9: Going to single-link mode, all senders are disabled no later than the cycle in which done goes out to every peer. rx_en[p] is cleared only after a done from peer p. pin_sel returns to 0 only after done from all peers, and mc_off clears only after the following pin_ack.
- R10: busy stays high for the whole transition. mode_multi changes only in the cycle in which the transition completes.
- R11: While busy, an assistant ignores new inquiries (no reply) and a launcher ignores eval_tick.
- R12: The role follows is_launcher: a launcher never answers inquiries, and an assistant ignores eval_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_launcher | input | 1 | Role strap: 1 launcher, 0 assistant |
| eval_tick | input | 1 | End of a decision interval (launcher only) |
| want_multi | input | 1 | Local traffic hint: 1 prefers multi-link mode |
| msg_in_vld | input | NPEER | Message valid, one bit per peer |
| msg_in_typ | input | 3*NPEER | Message type per peer |
| mc_ack | input | 1 | Pulse: memory controllers reached the commanded state |
| pin_ack | input | 1 | Pulse: pin switches settled at pin_sel |
| msg_out_vld | output | NPEER | Outgoing message valid per peer |
| msg_out_typ | output | 3*NPEER | Outgoing message type per peer |
| mc_off | output | 1 | Disable command to the switchable memory controller pair |
| pin_sel | output | 1 | Pin switch select: 1 routes pins to link lanes |
| rx_en | output | NPEER | Extra-lane receiver enable per peer |
| tx_en | output | NPEER | Extra-lane sender enable per peer |
| mode_multi | output | 1 | Current completed mode: 1 multi-link |
| busy | output | 1 | Agreement or transition in progress |

## Verification
Two things can land in the same cycle. During polling, a deny from one peer can coincide with the final approval from the others. The bench drives both in one cycle and then expects idle, no request message, and every local output still at its previous value. A neighbour's done can also arrive while the agent is still waiting for its own memory-controller acknowledge. The bench sends that done early and then judges that the matching sender comes on one cycle after the local done goes out, while the other senders stay off until their own dones arrive.

// File: rtl/xlm_pkg.sv
package xlm_pkg;

    localparam int MSG_W = 3;

    typedef enum logic [2:0] {
        MSG_NONE    = 3'd0,
        MSG_INQ     = 3'd1,
        MSG_APPROVE = 3'd2,
        MSG_DENY    = 3'd3,
        MSG_REQ     = 3'd4,
        MSG_DONE    = 3'd5
    } msg_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,
        ST_WAIT_REQ,
        ST_MC_OFF,
        ST_PIN_LINK,
        ST_WAIT_UP,
        ST_TX_OFF,
        ST_WAIT_DN,
        ST_PIN_MEM,
        ST_MC_ON
    } state_e;

    typedef struct packed {
        logic track;
        logic rx_on_all;
        logic rx_off_gate;
        logic tx_on_gate;
        logic tx_off_all;
    } lane_ctl_t;

    function automatic msg_e reply_for(logic want_multi, logic mode_multi);
        return (want_multi != mode_multi) ? MSG_APPROVE : MSG_DENY;
    endfunction

    function automatic state_e commit_state(logic mode_multi);
        return mode_multi ? ST_TX_OFF : ST_MC_OFF;
    endfunction

endpackage

// File: rtl/xlm_wait_timer.sv
module xlm_wait_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(TIMEOUT));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/xlm_peer_slot.sv
module xlm_peer_slot
    import xlm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [MSG_W-1:0] typ,
    input  lane_ctl_t        ctl,
    output logic             inq,
    output logic             req,
    output logic             approved,
    output logic             denied,
    output logic             done,
    output logic             rx_en,
    output logic             tx_en
);
    logic approve_q;
    logic done_q;
    logic approve_now;
    logic done_now;

    assign inq         = vld && (typ == MSG_INQ);
    assign req         = vld && (typ == MSG_REQ);
    assign denied      = vld && (typ == MSG_DENY);
    assign approve_now = vld && (typ == MSG_APPROVE);
    assign done_now    = ctl.track && vld && (typ == MSG_DONE);
    assign approved    = approve_q || approve_now;
    assign done        = done_q || done_now;

    always_ff @(posedge clk) begin
        if (rst || !ctl.track) begin
            approve_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (approve_now) approve_q <= 1'b1;
            if (done_now)    done_q    <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            if (ctl.rx_on_all)                rx_en <= 1'b1;
            else if (ctl.rx_off_gate && done) rx_en <= 1'b0;
            if (ctl.tx_off_all)               tx_en <= 1'b0;
            else if (ctl.tx_on_gate && done)  tx_en <= 1'b1;
        end
    end
endmodule

// File: rtl/xlm_sequencer.sv
module xlm_sequencer
    import xlm_pkg::*;
#(
    parameter int NPEER = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   is_launcher,
    input  logic                   eval_tick,
    input  logic                   want_multi,
    input  logic [NPEER-1:0]       inq_vec,
    input  logic                   req_any,
    input  logic                   appr_all,
    input  logic                   deny_any,
    input  logic                   done_all,
    input  logic                   expired,
    input  logic                   mc_ack,
    input  logic                   pin_ack,
    output state_e                 state,
    output lane_ctl_t              ctl,
    output logic [NPEER-1:0]       out_vld,
    output logic [MSG_W*NPEER-1:0] out_typ,
    output logic                   mc_off,
    output logic                   pin_sel,
    output logic                   mode_multi
);
    localparam logic [NPEER-1:0] LSB_ONE = NPEER'(1);

    logic [NPEER-1:0] inq_pick;
    msg_e             reply;

    assign inq_pick = inq_vec & ((~inq_vec) + LSB_ONE);
    assign reply    = reply_for(want_multi, mode_multi);

    always_comb begin
        ctl.track       = (state != ST_IDLE);
        ctl.rx_on_all   = (state == ST_PIN_LINK) && pin_ack;
        ctl.rx_off_gate = (state == ST_WAIT_DN);
        ctl.tx_on_gate  = (state == ST_WAIT_UP);
        ctl.tx_off_all  = (state == ST_TX_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            out_vld    <= '0;
            out_typ    <= '0;
            mc_off     <= 1'b0;
            pin_sel    <= 1'b0;
            mode_multi <= 1'b0;
        end else begin
            out_vld <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (is_launcher) begin
                        if (eval_tick && (want_multi != mode_multi)) begin
                            out_vld <= '1;
                            out_typ <= {NPEER{MSG_INQ}};
                            state   <= ST_POLL;
                        end
                    end else if (|inq_vec) begin
                        out_vld <= inq_pick;
                        out_typ <= {NPEER{reply}};
                        if (reply == MSG_APPROVE) state <= ST_WAIT_REQ;
                    end
                end
                ST_POLL: begin
                    if (deny_any || expired) begin
                        state <= ST_IDLE;
                    end else if (appr_all) begin
                        out_vld <= '1;
                        out_typ <= {NPEER{MSG_REQ}};
                        state   <= commit_state(mode_multi);
                        if (!mode_multi) mc_off <= 1'b1;
                    end
                end
                ST_WAIT_REQ: begin
                    if (req_any) begin
                        state <= commit_state(mode_multi);
                        if (!mode_multi) mc_off <= 1'b1;
                    end else if (expired) begin
                        state <= ST_IDLE;
                    end
                end
                ST_MC_OFF: begin
                    if (mc_ack) begin
                        pin_sel <= 1'b1;
                        state   <= ST_PIN_LINK;
                    end
                end
                ST_PIN_LINK: begin
                    if (pin_ack) begin
                        out_vld <= '1;
                        out_typ <= {NPEER{MSG_DONE}};
                        state   <= ST_WAIT_UP;
                    end
                end
                ST_WAIT_UP: begin
                    if (done_all) begin
                        mode_multi <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                ST_TX_OFF: begin
                    out_vld <= '1;
                    out_typ <= {NPEER{MSG_DONE}};
                    state   <= ST_WAIT_DN;
                end
                ST_WAIT_DN: begin
                    if (done_all) begin
                        pin_sel <= 1'b0;
                        state   <= ST_PIN_MEM;
                    end
                end
                ST_PIN_MEM: begin
                    if (pin_ack) begin
                        mc_off <= 1'b0;
                        state  <= ST_MC_ON;
                    end
                end
                ST_MC_ON: begin
                    if (mc_ack) begin
                        mode_multi <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlink_mode_agent.sv
module xlink_mode_agent
    import xlm_pkg::*;
#(
    parameter int NPEER   = 3,
    parameter int TIMEOUT = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   is_launcher,
    input  logic                   eval_tick,
    input  logic                   want_multi,
    input  logic [NPEER-1:0]       msg_in_vld,
    input  logic [3*NPEER-1:0]     msg_in_typ,
    input  logic                   mc_ack,
    input  logic                   pin_ack,
    output logic [NPEER-1:0]       msg_out_vld,
    output logic [3*NPEER-1:0]     msg_out_typ,
    output logic                   mc_off,
    output logic                   pin_sel,
    output logic [NPEER-1:0]       rx_en,
    output logic [NPEER-1:0]       tx_en,
    output logic                   mode_multi,
    output logic                   busy
);
    state_e           state;
    lane_ctl_t        ctl;
    logic [NPEER-1:0] inq_v, req_v, appr_v, deny_v, done_v;
    logic             expired;

    for (genvar p = 0; p < NPEER; p++) begin : g_peer
        xlm_peer_slot slot_i (
            .clk      (clk),
            .rst      (rst),
            .vld      (msg_in_vld[p]),
            .typ      (msg_in_typ[MSG_W*p +: MSG_W]),
            .ctl      (ctl),
            .inq      (inq_v[p]),
            .req      (req_v[p]),
            .approved (appr_v[p]),
            .denied   (deny_v[p]),
            .done     (done_v[p]),
            .rx_en    (rx_en[p]),
            .tx_en    (tx_en[p])
        );
    end

    xlm_wait_timer #(.TIMEOUT(TIMEOUT)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .run     ((state == ST_POLL) || (state == ST_WAIT_REQ)),
        .expired (expired)
    );

    xlm_sequencer #(.NPEER(NPEER)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .is_launcher (is_launcher),
        .eval_tick   (eval_tick),
        .want_multi  (want_multi),
        .inq_vec     (inq_v),
        .req_any     (|req_v),
        .appr_all    (&appr_v),
        .deny_any    (|deny_v),
        .done_all    (&done_v),
        .expired     (expired),
        .mc_ack      (mc_ack),
        .pin_ack     (pin_ack),
        .state       (state),
        .ctl         (ctl),
        .out_vld     (msg_out_vld),
        .out_typ     (msg_out_typ),
        .mc_off      (mc_off),
        .pin_sel     (pin_sel),
        .mode_multi  (mode_multi)
    );

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/xlm_agent_checker.sv
module xlm_agent_checker #(
    parameter int NPEER = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_multi,
    input logic             busy,
    input logic             mc_off,
    input logic             pin_sel,
    input logic [NPEER-1:0] rx_en,
    input logic [NPEER-1:0] tx_en
);
    assert_pins_after_mc_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_sel) |-> mc_off);

    assert_rx_after_pins_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(|rx_en) |-> (pin_sel && mc_off));

    assert_tx_needs_rx_R8: assert property (@(posedge clk) disable iff (rst)
        (|tx_en) |-> (&rx_en));

    assert_lanes_off_before_pins_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_sel) |-> (rx_en == '0 && tx_en == '0));

    assert_mc_on_after_pins_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(mc_off) |-> !pin_sel);

    assert_idle_consistent_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pin_sel == mode_multi && mc_off == mode_multi &&
                   rx_en == {NPEER{mode_multi}} && tx_en == {NPEER{mode_multi}}));

    assert_mode_flips_at_end_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_multi) |-> !busy);
endmodule

bind xlink_mode_agent xlm_agent_checker #(.NPEER(NPEER)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_multi (mode_multi),
    .busy       (busy),
    .mc_off     (mc_off),
    .pin_sel    (pin_sel),
    .rx_en      (rx_en),
    .tx_en      (tx_en)
);

// File: tb/xlink_mode_agent_tb_top.sv
module xlink_mode_agent_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int TO = 8;

    localparam logic [2:0] T_INQ = 3'd1, T_APP = 3'd2, T_DENY = 3'd3, T_REQ = 3'd4, T_DONE = 3'd5;

    logic clk = 1'b0;
    logic rst;
    logic is_launcher, eval_tick, want_multi, mc_ack, pin_ack;
    logic [NP-1:0]   msg_in_vld;
    logic [3*NP-1:0] msg_in_typ;
    logic [NP-1:0]   msg_out_vld, rx_en, tx_en;
    logic [3*NP-1:0] msg_out_typ;
    logic mc_off, pin_sel, mode_multi, busy;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlink_mode_agent #(.NPEER(NP), .TIMEOUT(TO)) dut_i (
        .clk(clk), .rst(rst), .is_launcher(is_launcher), .eval_tick(eval_tick),
        .want_multi(want_multi), .msg_in_vld(msg_in_vld), .msg_in_typ(msg_in_typ),
        .mc_ack(mc_ack), .pin_ack(pin_ack), .msg_out_vld(msg_out_vld),
        .msg_out_typ(msg_out_typ), .mc_off(mc_off), .pin_sel(pin_sel),
        .rx_en(rx_en), .tx_en(tx_en), .mode_multi(mode_multi), .busy(busy)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic put(int p, logic [2:0] t);
        msg_in_vld[p] = 1'b1;
        msg_in_typ[3*p +: 3] = t;
    endtask

    task automatic step();
        @(negedge clk);
        msg_in_vld = '0;
        msg_in_typ = '0;
        eval_tick  = 1'b0;
        mc_ack     = 1'b0;
        pin_ack    = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mode", mode_multi, 0);
        check("R1 busy", busy, 0);
        check("R1 mc_off/pin_sel", {mc_off, pin_sel}, 0);
        check("R1 rx/tx", {rx_en, tx_en}, 0);
        check("R1 out_vld", msg_out_vld, 0);
    endtask

    task automatic t_launcher_noops();
        is_launcher = 1'b1;
        want_multi  = 1'b0;
        eval_tick   = 1'b1;
        step();
        check("R2 tick same mode no inquiry", msg_out_vld, 0);
        check("R2 tick same mode not busy", busy, 0);
        put(1, T_INQ);
        step();
        check("R12 launcher ignores inquiry", msg_out_vld, 0);
        check("R12 launcher stays idle", busy, 0);
    endtask

    task automatic t_launch_to_multi();
        is_launcher = 1'b1;
        want_multi  = 1'b1;
        eval_tick   = 1'b1;
        step();
        check("R2 inquiry to all", msg_out_vld, 3'b111);
        check("R2 inquiry type", msg_out_typ, {NP{T_INQ}});
        check("R10 busy in poll", busy, 1);
        put(0, T_APP);
        step();
        check("R6 no request on partial approvals", msg_out_vld, 0);
        put(1, T_APP); put(2, T_APP);
        step();
        check("R6 request to all", msg_out_vld, 3'b111);
        check("R6 request type", msg_out_typ, {NP{T_REQ}});
        check("R7 mc_off first", {mc_off, pin_sel}, 2'b10);
        put(1, T_DONE);
        eval_tick = 1'b1;
        step();
        check("R11 tick ignored while busy", msg_out_vld, 0);
        check("R7 pins wait for mc_ack", pin_sel, 0);
        mc_ack = 1'b1;
        step();
        check("R7 pins after mc_ack", pin_sel, 1);
        check("R7 rx waits for pin_ack", rx_en, 0);
        pin_ack = 1'b1;
        step();
        check("R7 rx all on", rx_en, 3'b111);
        check("R7 done to all", msg_out_vld, 3'b111);
        check("R7 done type", msg_out_typ, {NP{T_DONE}});
        check("R8 tx off when done sent", tx_en, 0);
        step();
        check("R8 early done remembered", tx_en, 3'b010);
        check("R10 mode held mid transition", {mode_multi, busy}, 2'b01);
        put(0, T_DONE);
        step();
        check("R8 tx after peer0 done", tx_en, 3'b011);
        put(2, T_DONE);
        step();
        check("R8 all tx on", tx_en, 3'b111);
        check("R10 mode flips at end", {mode_multi, busy}, 2'b10);
    endtask

    task automatic t_deny_same_cycle();
        want_multi = 1'b0;
        eval_tick  = 1'b1;
        step();
        check("R2 inquiry from multi", msg_out_vld, 3'b111);
        put(0, T_APP);
        step();
        put(1, T_APP); put(2, T_DENY);
        step();
        check("R4 abort on deny with last approval", busy, 0);
        check("R4 no request", msg_out_vld, 0);
        check("R4 outputs unchanged", {mode_multi, mc_off, pin_sel, rx_en, tx_en}, 9'h1FF);
        step();
        check("R4 still no request", msg_out_vld, 0);
    endtask

    task automatic t_launch_timeout();
        eval_tick = 1'b1;
        step();
        put(0, T_APP);
        for (int i = 0; i < TO; i++) step();
        check("R5 still polling before timeout", busy, 1);
        step();
        check("R5 timeout returns idle", busy, 0);
        check("R5 no request after timeout", msg_out_vld, 0);
        check("R5 mode unchanged", {mode_multi, pin_sel}, 2'b11);
    endtask

    task automatic t_assist_to_single();
        is_launcher = 1'b0;
        want_multi  = 1'b1;
        put(2, T_INQ);
        step();
        check("R3 deny only to peer2", msg_out_vld, 3'b100);
        check("R3 deny type", msg_out_typ[8:6], T_DENY);
        check("R3 deny stays idle", busy, 0);
        want_multi = 1'b0;
        put(1, T_INQ);
        step();
        check("R3 approve only to peer1", msg_out_vld, 3'b010);
        check("R3 approve type", msg_out_typ[5:3], T_APP);
        check("R3 approve busy", busy, 1);
        put(0, T_INQ);
        eval_tick = 1'b1;
        step();
        check("R11 inquiry ignored while busy", msg_out_vld, 0);
        put(1, T_REQ);
        step();
        check("R9 tx still on at request", tx_en, 3'b111);
        step();
        check("R9 tx off with done", tx_en, 0);
        check("R9 done to all", msg_out_vld, 3'b111);
        check("R9 done type", msg_out_typ, {NP{T_DONE}});
        check("R9 rx kept before neighbour done", rx_en, 3'b111);
        put(0, T_DONE);
        step();
        check("R9 rx0 off after its done", rx_en, 3'b110);
        check("R9 pins held", pin_sel, 1);
        put(1, T_DONE); put(2, T_DONE);
        step();
        check("R9 rx all off", rx_en, 0);
        check("R9 pins back after all done", {pin_sel, mc_off}, 2'b01);
        pin_ack = 1'b1;
        step();
        check("R9 mc on after pin_ack", mc_off, 0);
        check("R10 mode held until mc_ack", {mode_multi, busy}, 2'b11);
        mc_ack = 1'b1;
        step();
        check("R10 single mode done", {mode_multi, busy}, 2'b00);
    endtask

    task automatic t_assist_timeout();
        want_multi = 1'b1;
        put(0, T_INQ);
        step();
        check("R3 approve to peer0", msg_out_vld, 3'b001);
        for (int i = 0; i < TO; i++) step();
        check("R5 assistant waits", busy, 1);
        step();
        check("R5 assistant gives up", busy, 0);
        check("R5 assistant mode unchanged", {mode_multi, mc_off}, 2'b00);
    endtask

    initial begin
        rst = 1'b1;
        is_launcher = 1'b1; eval_tick = 1'b0; want_multi = 1'b0;
        mc_ack = 1'b0; pin_ack = 1'b0; msg_in_vld = '0; msg_in_typ = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_launcher_noops();
        t_launch_to_multi();
        t_deny_same_cycle();
        t_launch_timeout();
        t_assist_to_single();
        t_assist_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule